// File: doc/BRIEF.md
# Banked Flash Read Stall-and-Retry Controller

This block sits between a pipelined read port on the system bus and a banked flash array. The array can be busy with a program or erase operation. A bank counts as busy whenever its done indication is low. Each bank has a 3-bit response code that decides what happens to a read aimed at that bank while it is busy. If the top bit of the code is clear, the read is ended at once with a two-cycle error response and never reaches the array. If the top bit is set, the bus is stalled and the read's address and attributes are kept. As soon as the bank reports done again, a pseudo address phase replays the read into the array. 3'b111 is the default stall setting, and codes 3'b100 through 3'b110 behave identically to it.

The bus side uses a valid/ready handshake. A read address is taken on a rising edge where `bus_valid` and `bus_ready` are both high. While `bus_ready` is low, the master must hold its next request and the block does not look at it. Exactly one read is outstanding at a time. `bus_ready` stays low from acceptance until that read's data or error is presented. The array request port has no back-pressure, because it is only driven when the target bank is not busy. If a bank's done falls while a read is in flight, the in-flight read is dropped. The read is then either replayed or errored, according to the bank's code at that moment.

Top module: `rww_read_ctrl`

## Requirements
- R1: After reset, `bus_ready` is 1, `bus_err` is 0 and `arr_req` is 0 until a read is presented.
- R2: A read accepted while its bank's done is 1 raises `arr_req` in the same cycle, with `arr_addr`/`arr_attr` equal to the bus address and attributes.
- R3: Read data present on `arr_rdata` with `arr_rvalid` high in an edge, with the bank still done, appears on `bus_rdata` in the next cycle with `bus_ready` 1 and `bus_err` 0. Before that cycle, `bus_ready` is 0.
- R4: A read accepted while its bank is busy and that bank's code has bit 2 equal to 0 causes no `arr_req`. The next cycle shows `bus_ready`=0 with `bus_err`=1, and the cycle after shows `bus_ready`=1 with `bus_err`=1.
- R5: A read accepted while its bank is busy and that bank's code has bit 2 equal to 1 holds `bus_ready` low, with no `arr_req`, for as long as the bank stays busy.
- R6: In the first cycle a stalled read's bank shows done=1, `arr_req` is raised carrying the saved address and attributes. The read then completes as in R3.
- R7: If the bank's done is 0 at an edge while a read is in flight in the array, that read's data is discarded. The read is then stalled and replayed (bit 2 set) or given the R4 error sequence (bit 2 clear).
- R8: The bank of a read is address bits [BANK_LSB +: log2(NBANK)]. Bank k's code is `bank_mode[3k+2:3k]` and its done is `arr_done[k]`. A busy bank does not affect reads to another bank.
- R9: At most one read is outstanding: `arr_req` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Read address phase present |
| bus_addr | input | ADDR_W | Read address |
| bus_attr | input | ATTR_W | Read attributes |
| bus_ready | output | 1 | Address taken / previous data phase complete |
| bus_err | output | 1 | Error response (two cycles) |
| bus_rdata | output | DATA_W | Read data, valid when ready high and error low after a read |
| bank_mode | input | 3*NBANK | Per-bank busy-response code |
| arr_done | input | NBANK | Per-bank done, 0 while program/erase runs |
| arr_req | output | 1 | Array address phase |
| arr_addr | output | ADDR_W | Array address |
| arr_attr | output | ATTR_W | Array attributes |
| arr_rvalid | input | 1 | Array data valid |
| arr_rdata | input | DATA_W | Array read data |

## Verification
The array request of R2 and R6 is combinational, so it is due in the same cycle as the accepting or done-returning edge. The bus response of R3 is due one edge after array data, and the error pair of R4 is due one and two edges after acceptance. The bench drives inputs at the falling edge and evaluates a behavioural reference one time unit later, so every output is compared within the cycle it is due. State updates of model and array stub are applied just after the rising edge, once the design has sampled.

// File: rtl/rww_pkg.sv
package rww_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WAIT,
    ST_RESP,
    ST_ERR1,
    ST_ERR2
  } rww_state_e;

  typedef enum logic [1:0] {
    RESP_ERROR,
    RESP_STALL,
    RESP_STALL_ALT
  } rww_resp_e;

  function automatic rww_resp_e decode_mode(input logic [2:0] code);
    if (!code[2])            return RESP_ERROR;
    else if (code[1:0] == 2'b11) return RESP_STALL;
    else                     return RESP_STALL_ALT;
  endfunction

endpackage

// File: rtl/rww_bank_sel.sv
module rww_bank_sel
  import rww_pkg::*;
#(
  parameter int NBANK  = 2,
  parameter int BANK_W = 1
) (
  input  logic [BANK_W-1:0]  bank,
  input  logic [NBANK*3-1:0] mode_vec,
  input  logic [NBANK-1:0]   done_vec,
  output rww_resp_e          resp,
  output logic               busy
);
  logic [2:0] code;

  always_comb begin
    code = mode_vec[bank*3 +: 3];
    resp = decode_mode(code);
    busy = !done_vec[bank];
  end
endmodule

// File: rtl/rww_hold.sv
module rww_hold #(
  parameter int ADDR_W = 16,
  parameter int ATTR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_req,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [ATTR_W-1:0] in_attr,
  input  logic              cap_data,
  input  logic [DATA_W-1:0] in_data,
  output logic [ADDR_W-1:0] held_addr,
  output logic [ATTR_W-1:0] held_attr,
  output logic [DATA_W-1:0] data_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_addr <= '0;
      held_attr <= '0;
    end else if (cap_req) begin
      held_addr <= in_addr;
      held_attr <= in_attr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        data_q <= '0;
    else if (cap_data) data_q <= in_data;
  end
endmodule

// File: rtl/rww_fsm.sv
module rww_fsm
  import rww_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_valid,
  input  logic       live_busy,
  input  rww_resp_e  live_resp,
  input  logic       held_busy,
  input  rww_resp_e  held_resp,
  input  logic       arr_rvalid,
  output rww_state_e state,
  output logic       bus_ready,
  output logic       bus_err,
  output logic       accept,
  output logic       fwd_live,
  output logic       replay,
  output logic       cap_data
);
  rww_state_e nxt;

  always_comb begin
    bus_ready = (state == ST_IDLE) || (state == ST_RESP) || (state == ST_ERR2);
    bus_err   = (state == ST_ERR1) || (state == ST_ERR2);
    accept    = bus_valid && bus_ready;
    fwd_live  = accept && !live_busy;
    replay    = (state == ST_WAIT) && !held_busy;
    cap_data  = (state == ST_READ) && !held_busy && arr_rvalid;
  end

  always_comb begin
    nxt = state;
    if (accept) begin
      if (!live_busy)                   nxt = ST_READ;
      else if (live_resp == RESP_ERROR) nxt = ST_ERR1;
      else                              nxt = ST_WAIT;
    end else begin
      unique case (state)
        ST_READ: begin
          if (held_busy)       nxt = (held_resp == RESP_ERROR) ? ST_ERR1 : ST_WAIT;
          else if (arr_rvalid) nxt = ST_RESP;
        end
        ST_WAIT: if (!held_busy) nxt = ST_READ;
        ST_ERR1: nxt = ST_ERR2;
        ST_RESP, ST_ERR2: nxt = ST_IDLE;
        default: nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  // R4: error response is a low-ready cycle followed by a high-ready cycle
  a_r4_err_two_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_err && !bus_ready) |=> (bus_err && bus_ready));

  // R4: a busy read in error mode goes straight to the error sequence
  a_r4_err_on_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && live_busy && live_resp == RESP_ERROR) |=> (state == ST_ERR1));

  // R6: a replay moves the saved read into the array read phase
  a_r6_replay_reads: assert property (@(posedge clk) disable iff (!rst_n)
    replay |=> (state == ST_READ));

  // R7: an in-flight read hit by busy never produces a data response
  a_r7_abort_no_resp: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_READ && held_busy) |=> (state != ST_RESP));

  // R3: a data response always follows captured array data
  a_r3_resp_after_data: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RESP) |-> $past(cap_data));
endmodule

// File: rtl/rww_read_ctrl.sv
module rww_read_ctrl
  import rww_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int ATTR_W   = 4,
  parameter int DATA_W   = 32,
  parameter int NBANK    = 2,
  parameter int BANK_LSB = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_valid,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [ATTR_W-1:0]  bus_attr,
  output logic               bus_ready,
  output logic               bus_err,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [NBANK*3-1:0] bank_mode,
  input  logic [NBANK-1:0]   arr_done,
  output logic               arr_req,
  output logic [ADDR_W-1:0]  arr_addr,
  output logic [ATTR_W-1:0]  arr_attr,
  input  logic               arr_rvalid,
  input  logic [DATA_W-1:0]  arr_rdata
);
  localparam int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1;

  logic [ADDR_W-1:0] held_addr;
  logic [ATTR_W-1:0] held_attr;
  logic [BANK_W-1:0] live_bank, held_bank;
  rww_resp_e         live_resp, held_resp;
  logic              live_busy, held_busy;
  rww_state_e        state;
  logic              accept, fwd_live, replay, cap_data;

  generate
    if (NBANK > 1) begin : g_banked
      assign live_bank = bus_addr[BANK_LSB +: BANK_W];
      assign held_bank = held_addr[BANK_LSB +: BANK_W];
    end else begin : g_single
      assign live_bank = '0;
      assign held_bank = '0;
    end
  endgenerate

  rww_bank_sel #(.NBANK(NBANK), .BANK_W(BANK_W)) u_sel_live (
    .bank(live_bank), .mode_vec(bank_mode), .done_vec(arr_done),
    .resp(live_resp), .busy(live_busy)
  );

  rww_bank_sel #(.NBANK(NBANK), .BANK_W(BANK_W)) u_sel_held (
    .bank(held_bank), .mode_vec(bank_mode), .done_vec(arr_done),
    .resp(held_resp), .busy(held_busy)
  );

  rww_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid),
    .live_busy(live_busy), .live_resp(live_resp),
    .held_busy(held_busy), .held_resp(held_resp),
    .arr_rvalid(arr_rvalid), .state(state),
    .bus_ready(bus_ready), .bus_err(bus_err), .accept(accept),
    .fwd_live(fwd_live), .replay(replay), .cap_data(cap_data)
  );

  rww_hold #(.ADDR_W(ADDR_W), .ATTR_W(ATTR_W), .DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .cap_req(accept),
    .in_addr(bus_addr), .in_attr(bus_attr),
    .cap_data(cap_data), .in_data(arr_rdata),
    .held_addr(held_addr), .held_attr(held_attr), .data_q(bus_rdata)
  );

  always_comb begin
    arr_req  = fwd_live || replay;
    arr_addr = fwd_live ? bus_addr : held_addr;
    arr_attr = fwd_live ? bus_attr : held_attr;
  end

  // R9: one outstanding read, so array requests never come back to back
  a_r9_single_req: assert property (@(posedge clk) disable iff (!rst_n)
    arr_req |=> !arr_req);

  // R5: a stalled read keeps the bus held and the array untouched while busy
  a_r5_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT && held_busy) |-> (!arr_req && !bus_ready));

  // R6: replayed request carries the saved address
  a_r6_replay_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT && !held_busy) |-> (arr_req && arr_addr == held_addr));
endmodule

// File: tb/tb_rww_read_ctrl.sv
module tb_rww_read_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 16, ATTR_W = 4, DATA_W = 32, NBANK = 2, BANK_LSB = 12;
  localparam int NCYC = 640;

  logic clk = 0, rst_n = 0;
  logic bus_valid = 0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [ATTR_W-1:0] bus_attr = '0;
  logic bus_ready, bus_err, arr_req, arr_rvalid;
  logic [DATA_W-1:0] bus_rdata, arr_rdata;
  logic [NBANK*3-1:0] bank_mode = {3'b111, 3'b111};
  logic [NBANK-1:0] arr_done = '1;
  logic [ADDR_W-1:0] arr_addr;
  logic [ATTR_W-1:0] arr_attr;

  rww_read_ctrl #(.ADDR_W(ADDR_W), .ATTR_W(ATTR_W), .DATA_W(DATA_W),
                  .NBANK(NBANK), .BANK_LSB(BANK_LSB)) dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_addr(bus_addr),
    .bus_attr(bus_attr), .bus_ready(bus_ready), .bus_err(bus_err),
    .bus_rdata(bus_rdata), .bank_mode(bank_mode), .arr_done(arr_done),
    .arr_req(arr_req), .arr_addr(arr_addr), .arr_attr(arr_attr),
    .arr_rvalid(arr_rvalid), .arr_rdata(arr_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0, n_fail = 0;
  int a_cnt = 0, a_bank = 0;
  logic [ADDR_W-1:0] a_addr = '0;
  assign arr_rvalid = (a_cnt == 1);
  assign arr_rdata  = {~a_addr, a_addr};

  // reference model state: 0 idle, 1 read, 2 wait, 3 resp, 4 err1, 5 err2
  int m_st = 0, k = 0;
  logic [ADDR_W-1:0] m_addr = '0;
  logic [ATTR_W-1:0] m_attr = '0;
  logic [DATA_W-1:0] m_data = '0;
  int n_err_seen = 0, n_replay = 0, n_abort = 0, n_cross = 0;
  bit done_flag = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic bit in_win(input int c, input int lo, input int hi);
    return (c >= lo) && (c < hi);
  endfunction

  initial begin
    #(CLK_PERIOD*50000);
    if (!done_flag) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int lb, hb, nst;
    bit lbusy, hbusy, lerr, herr, e_ready, e_err, acc, e_req;
    logic [ADDR_W-1:0] e_addr;
    logic [ATTR_W-1:0] e_attr;
    string tag;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    for (int c = 0; c < NCYC; c++) begin
      @(negedge clk);
      // per-bank codes: bit 2 clear selects the error response
      if (c < 300)      bank_mode = {3'b111, 3'b111};
      else if (c < 450) bank_mode = {3'b010, 3'b101};
      else              bank_mode = {3'b110, 3'b000};
      arr_done[0] = !(in_win(c,40,70) || in_win(c,120,123) || in_win(c,200,260) ||
                      in_win(c,330,360) || in_win(c,470,500) ||
                      (c >= 260 && c < 300 && (c % 7) == 3) ||
                      (c >= 560 && (c % 11) == 2));
      arr_done[1] = !(in_win(c,150,180) || in_win(c,340,370) ||
                      in_win(c,480,490) || in_win(c,520,530) ||
                      (c >= 400 && c < 450 && (c % 9) == 1));
      bus_valid = (c >= 5) && ((c % 9) != 4);
      bus_addr  = ADDR_W'((((k ^ (k >> 2)) & 1) << BANK_LSB) | ((k * 4) & 12'hffc));
      bus_attr  = ATTR_W'(k);
      #1;
      lb = int'(bus_addr[BANK_LSB]);
      hb = int'(m_addr[BANK_LSB]);
      lbusy = !arr_done[lb];  hbusy = !arr_done[hb];
      lerr  = !bank_mode[lb*3+2]; herr = !bank_mode[hb*3+2];
      e_ready = (m_st == 0) || (m_st == 3) || (m_st == 5);
      e_err   = (m_st == 4) || (m_st == 5);
      acc     = bus_valid && e_ready;
      e_req   = (acc && !lbusy) || (m_st == 2 && !hbusy);
      e_addr  = acc ? bus_addr : m_addr;
      e_attr  = acc ? bus_attr : m_attr;

      if (c < 5)                          tag = "R1";
      else if (m_st == 1 && hbusy)        tag = "R7";
      else if (m_st == 2)                 tag = hbusy ? "R5" : "R6";
      else if (m_st == 4 || m_st == 5)    tag = "R4";
      else if (m_st == 1 || m_st == 3)    tag = "R3";
      else if (acc && !lbusy && !arr_done[1-lb]) tag = "R8";
      else                                tag = "R2";

      chk(bus_ready === e_ready, tag, "bus_ready", longint'(bus_ready), longint'(e_ready));
      chk(bus_err === e_err, tag, "bus_err", longint'(bus_err), longint'(e_err));
      chk(arr_req === e_req, (e_req || m_st == 2) ? tag : "R9", "arr_req",
          longint'(arr_req), longint'(e_req));
      if (e_req) begin
        chk(arr_addr === e_addr, tag, "arr_addr", longint'(arr_addr), longint'(e_addr));
        chk(arr_attr === e_attr, tag, "arr_attr", longint'(arr_attr), longint'(e_attr));
      end
      if (m_st == 3)
        chk(bus_rdata === m_data, "R3", "bus_rdata", longint'(bus_rdata), longint'(m_data));

      // next model state from the requirements
      nst = m_st;
      if (acc) begin
        if (!lbusy)    nst = 1;
        else if (lerr) begin nst = 4; n_err_seen++; end
        else           nst = 2;
        if (!lbusy && !arr_done[1-lb]) n_cross++;
      end else begin
        case (m_st)
          1: if (hbusy) begin nst = herr ? 4 : 2; n_abort++; if (herr) n_err_seen++; end
             else if (arr_rvalid) nst = 3;
          2: if (!hbusy) begin nst = 1; n_replay++; end
          4: nst = 5;
          3, 5: nst = 0;
          default: nst = m_st;
        endcase
      end

      @(posedge clk);
      #1;
      if (acc) begin m_addr = bus_addr; m_attr = bus_attr; k++; end
      if (m_st == 1 && !hbusy && arr_rvalid) m_data = arr_rdata;
      m_st = nst;
      if (e_req) begin a_cnt = 2; a_addr = e_addr; a_bank = int'(e_addr[BANK_LSB]); end
      else if (a_cnt > 0) begin
        if (!arr_done[a_bank]) a_cnt = 0;
        else a_cnt--;
      end
    end
    // scenario coverage checks
    chk(n_err_seen > 0, "R4", "error responses seen", n_err_seen, 1);
    chk(n_replay > 0, "R6", "replays seen", n_replay, 1);
    chk(n_abort > 0, "R7", "in-flight aborts seen", n_abort, 1);
    chk(n_cross > 0, "R8", "reads beside a busy bank", n_cross, 1);
    done_flag = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule